// File: doc/BRIEF.md
# ADC Power-Up Initialization Sequencer

This block sits in the digital back end of a stereo audio converter. It runs on the master clock and decides when converted samples may reach the rest of the chip. When the active-low power-down input is low, the block holds the decimation filter in reset and drives both channel words to two's-complement zero. When power-down is released, it waits for the frame (left/right) clock to run. The first recognised rising edge of the frame clock starts an initialization window of a fixed number of frame periods. Zero data still goes out during this window. After the window it passes the incoming left and right words through.

The frame clock is asynchronous to the master clock. It is brought across with a two-flop synchronizer, and rising edges are taken from the synchronized copy. During initialization and normal operation, a watchdog counts master-clock cycles since the last frame edge. If the frame clock stops, the block drops back to the wait state: the filter goes back into reset, the outputs go back to zero, and a later restart of the frame clock runs the whole initialization again.

Top module: `adc_pwrup_seq`

## Requirements
- R1: While `pdn_n` is low, `phase` is 00, `out_vld` is 0 and both output words are zero. This holds at once, without waiting for a master-clock edge, from any previous phase.
- R2: `filt_rst` is 1 in phases 00 and 01 and 0 in phases 10 and 11.
- R3: At the first master-clock rising edge after `pdn_n` goes high, `phase` moves from 00 to 01. It stays at 01, for any length of time, until a frame-clock rising edge is recognised.
- R4: A frame-clock rise is present at one master-clock rising edge. The phase change it causes takes effect at the second master-clock rising edge after that one.
- R5: The frame edge that leaves phase 01 starts phase 10. Phase 10 ends on the INIT_FRAMES-th recognised frame edge after that one, which moves `phase` to 11.
- R6: At every master-clock edge taken in a phase other than 11, `out_l`, `out_r` and `out_vld` are loaded with zero.
- R7: At every master-clock edge taken in phase 11, `out_vld` is loaded with `smp_vld`. When `smp_vld` is 1, `out_l` and `out_r` are loaded with `smp_l` and `smp_r` unchanged. Otherwise the words hold their values.
- R8: In phase 10 or 11, a run of TMO_CYCLES consecutive master-clock edges with no recognised frame edge returns `phase` to 01. A later frame edge then starts a full initialization of INIT_FRAMES periods.
- R9: `phase` encodes 00 as power-down, 01 as waiting for the frame clock, 10 as initializing and 11 as normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| pdn_n | input | 1 | Active-low power-down; also the asynchronous reset of the block |
| frame_clk | input | 1 | Frame (left/right) clock, asynchronous to `clk` |
| smp_vld | input | 1 | Strobe marking a new sample pair on `smp_l`/`smp_r` |
| smp_l | input | DW | Left-channel sample, two's complement |
| smp_r | input | DW | Right-channel sample, two's complement |
| filt_rst | output | 1 | Synchronous reset request for the downstream filter |
| phase | output | 2 | Current phase, encoded as in R9 |
| out_vld | output | 1 | Strobe for `out_l`/`out_r` |
| out_l | output | DW | Left-channel output word |
| out_r | output | DW | Right-channel output word |

## Verification
A wrong internal state shows up on `phase` and `filt_rst` in the cycle after the bad transition. A wrong frame-edge count or a wrong idle count shows no sign until normal operation starts or stops at the wrong frame edge. That error is caught by counting frame-clock rises at the pins between entering phase 10 and entering phase 11, and by stopping the frame clock for longer than the timeout. A lost synchronizer stage moves entry into initialization by one cycle, which the latency check for R4 catches. A word leaking out during initialization, or after a timeout, appears on `out_l`/`out_r` one edge later. The per-cycle reference comparison catches it.

// File: rtl/adc_pwrup_seq.sv
module adc_pwrup_seq #(
  parameter int DW          = 16,
  parameter int INIT_FRAMES = 4128,
  parameter int TMO_CYCLES  = 2048
) (
  input  logic          clk,
  input  logic          pdn_n,
  input  logic          frame_clk,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp_l,
  input  logic [DW-1:0] smp_r,
  output logic          filt_rst,
  output logic [1:0]    phase,
  output logic          out_vld,
  output logic [DW-1:0] out_l,
  output logic [DW-1:0] out_r
);
  localparam int CW = $clog2(INIT_FRAMES + 1);
  localparam int TW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(INIT_FRAMES - 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYCLES - 1);

  typedef enum logic [1:0] {
    PH_DOWN = 2'b00,
    PH_WAIT = 2'b01,
    PH_INIT = 2'b10,
    PH_RUN  = 2'b11
  } phase_t;

  phase_t        st;
  logic [2:0]    fsync;
  logic [CW-1:0] fcnt;
  logic [TW-1:0] idle;
  logic          fr_rise;
  logic          live;
  logic          expired;

  assign fr_rise  = fsync[1] & ~fsync[2];
  assign live     = (st == PH_INIT) || (st == PH_RUN);
  assign expired  = live && !fr_rise && (idle == TMO_LAST);
  assign filt_rst = !live;
  assign phase    = st;

  always_ff @(posedge clk or negedge pdn_n)
    if (!pdn_n) fsync <= '1;
    else        fsync <= {fsync[1:0], frame_clk};

  always_ff @(posedge clk or negedge pdn_n) begin
    if (!pdn_n) begin
      st   <= PH_DOWN;
      fcnt <= '0;
      idle <= '0;
    end else begin
      case (st)
        PH_DOWN: st <= PH_WAIT;
        PH_WAIT: if (fr_rise) begin
          st   <= PH_INIT;
          fcnt <= '0;
          idle <= '0;
        end
        default: if (fr_rise) begin
          idle <= '0;
          if (st == PH_INIT) begin
            if (fcnt == CNT_LAST) st <= PH_RUN;
            fcnt <= fcnt + 1'b1;
          end
        end else if (expired) begin
          st   <= PH_WAIT;
          idle <= '0;
        end else begin
          idle <= idle + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge pdn_n) begin
    if (!pdn_n) begin
      out_vld <= 1'b0;
      out_l   <= '0;
      out_r   <= '0;
    end else if (st != PH_RUN) begin
      out_vld <= 1'b0;
      out_l   <= '0;
      out_r   <= '0;
    end else begin
      out_vld <= smp_vld;
      if (smp_vld) begin
        out_l <= smp_l;
        out_r <= smp_r;
      end
    end
  end

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!pdn_n)
    (st == PH_WAIT && !fr_rise) |=> (st == PH_WAIT)); // R3
  AST_INIT_ENTRY: assert property (@(posedge clk) disable iff (!pdn_n)
    (st == PH_WAIT && fr_rise) |=> (st == PH_INIT && fcnt == '0)); // R4
  AST_RUN_FROM_INIT: assert property (@(posedge clk) disable iff (!pdn_n)
    (st == PH_RUN) |-> ($past(st) == PH_RUN || $past(st) == PH_INIT)); // R5
  AST_ZERO_OUT: assert property (@(posedge clk) disable iff (!pdn_n)
    (st != PH_RUN) |=> (out_l == '0 && out_r == '0 && !out_vld)); // R6
  AST_TIMEOUT: assert property (@(posedge clk) disable iff (!pdn_n)
    (live && !fr_rise && idle == TMO_LAST) |=> (st == PH_WAIT)); // R8
  AST_FILT_IDLE: assert property (@(posedge clk) disable iff (!pdn_n)
    (st == PH_WAIT) |-> filt_rst); // R2
endmodule

// File: tb/adc_pwrup_seq_tb.sv
`timescale 1ns/1ps
module adc_pwrup_seq_tb;
  localparam int DW = 16, NF = 6, TMO = 40, HALF = 8;

  logic clk = 1'b0, pdn_n = 1'b1, fc = 1'b0, vld = 1'b0;
  logic [DW-1:0] sl = '0, sr = '0;
  logic filt_rst, out_vld;
  logic [1:0] phase;
  logic [DW-1:0] out_l, out_r;
  int checks = 0, errors = 0, tick = 0, cyc = 0, rises = 0, div = 0;
  bit fc_mode = 0, running = 0, done = 0;

  always #2.5 clk = ~clk;

  adc_pwrup_seq #(.DW(DW), .INIT_FRAMES(NF), .TMO_CYCLES(TMO)) u_dut (
    .clk(clk), .pdn_n(pdn_n), .frame_clk(fc), .smp_vld(vld), .smp_l(sl), .smp_r(sr),
    .filt_rst(filt_rst), .phase(phase), .out_vld(out_vld), .out_l(out_l), .out_r(out_r));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model
  int m_ph, m_cnt, m_idle;
  bit m_edge, m_ov;
  logic [DW-1:0] m_ol, m_or;
  bit hist[$];
  always @(posedge clk or negedge pdn_n) begin
    if (!pdn_n) begin
      m_ph = 0; m_cnt = 0; m_idle = 0; m_ov = 0; m_ol = '0; m_or = '0;
      hist = '{1'b1, 1'b1, 1'b1};
    end else begin
      m_edge = hist[1] && !hist[0];
      if (m_ph == 3) begin
        m_ov = vld;
        if (vld) begin m_ol = sl; m_or = sr; end
      end else begin
        m_ov = 0; m_ol = '0; m_or = '0;
      end
      case (m_ph)
        0: m_ph = 1;
        1: if (m_edge) begin m_ph = 2; m_cnt = 0; m_idle = 0; end
        default: if (m_edge) begin
          m_idle = 0;
          if (m_ph == 2) begin m_cnt++; if (m_cnt == NF) m_ph = 3; end
        end else begin
          m_idle++;
          if (m_idle == TMO) begin m_ph = 1; m_idle = 0; end
        end
      endcase
      hist.push_back(fc);
      void'(hist.pop_front());
    end
  end

  // per-cycle compare, then drive inputs
  always @(negedge clk) begin
    if (pdn_n && !done) begin
      check(phase == 2'(m_ph), "R9", "phase", phase, m_ph);
      check(filt_rst == (m_ph < 2), "R2", "filt_rst", filt_rst, m_ph < 2);
      check(out_l == m_ol && out_r == m_or, (m_ph == 3) ? "R7" : "R6", "words",
            {out_l, out_r}, {m_ol, m_or});
      check(out_vld == m_ov, "R7", "out_vld", out_vld, m_ov);
    end
    tick++;
    if (fc_mode) begin
      if (!running) begin div = 0; running = 1; end
      else div = (div + 1) % (2 * HALF);
      if (div < HALF && !fc) rises++;
      fc = (div < HALF);
    end else begin
      running = 0;
      fc = 1'b0;
    end
    vld = (tick % 3) != 0;
    if (tick % 7 == 0) begin sl = 16'h8000; sr = 16'h7FFF; end
    else begin sl = DW'(tick * 40503); sr = ~sl; end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_phase(input logic [1:0] p);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #1;
      if (phase == p) return;
    end
  endtask

  task automatic power_down();
    @(negedge clk); #1;
    pdn_n = 1'b0;
    #0.5;
    check(phase == 2'b00, "R1", "phase at pdn", phase, 0);
    check(out_l == '0 && out_r == '0 && !out_vld, "R1", "outputs at pdn", {out_l, out_r}, 0);
    check(filt_rst, "R2", "filt_rst at pdn", filt_rst, 1);
  endtask

  initial begin
    int t0, base;
    #1 pdn_n = 1'b0;
    #2;
    check(phase == 2'b00 && !out_vld && out_l == '0, "R1", "reset state", phase, 0);
    repeat (4) @(negedge clk);
    #1 pdn_n = 1'b1;
    @(negedge clk); #1;
    check(phase == 2'b01, "R3", "wait after release", phase, 1);
    repeat (100) @(negedge clk);
    #1 check(phase == 2'b01, "R3", "still waiting without frame clock", phase, 1);
    // R4 latency
    fc_mode = 1;
    @(negedge clk); #1;
    t0 = tick;
    wait_phase(2'b10);
    check(tick - t0 == 3, "R4", "edge to init latency", tick - t0, 3);
    base = rises;
    wait_phase(2'b11);
    check(rises - base == NF, "R5", "frames in init", rises - base, NF);
    repeat (60) @(negedge clk);
    // R8 timeout
    fc_mode = 0;
    repeat (TMO + 20) @(negedge clk);
    #1 check(phase == 2'b01, "R8", "timeout to wait", phase, 1);
    check(out_l == '0 && out_r == '0, "R6", "zero after timeout", {out_l, out_r}, 0);
    fc_mode = 1;
    wait_phase(2'b10);
    check(phase == 2'b10, "R8", "reinit after restart", phase, 2);
    base = rises;
    wait_phase(2'b11);
    check(rises - base == NF, "R8", "full init repeated", rises - base, NF);
    repeat (30) @(negedge clk);
    // R1 from normal operation
    power_down();
    repeat (5) @(negedge clk);
    #1 check(phase == 2'b00 && out_l == '0, "R1", "held in pdn", phase, 0);
    pdn_n = 1'b1;
    @(negedge clk); #1;
    check(phase == 2'b01, "R3", "wait after second release", phase, 1);
    wait_phase(2'b10);
    repeat (20) @(negedge clk);
    // R1 from initialization
    power_down();
    repeat (3) @(negedge clk);
    #1 pdn_n = 1'b1;
    wait_phase(2'b11);
    check(phase == 2'b11, "R5", "normal after third init", phase, 3);
    repeat (40) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule